// File: doc/BRIEF.md
# Status Register Write-Lock Controller

This block keeps the protection status byte of a serial memory device and decides, for each write-status command, whether the new byte is taken or refused. The command decoder hands it a one-cycle request with a data byte. A separate pulse sets the write-enable latch. The write-protect pin is sampled as an active-low level. The block reports the outcome as a one-cycle accept or reject pulse. It also drives the four block-protect bits to the array-protection logic, which maps them to address ranges.

The lock rule uses two inputs. If the write-protect pin is low and the lock-down bit of the stored byte is set, the write is refused. If the lock-down bit is clear, or the pin is high, the write goes ahead, provided the write-enable latch is set. Every attempt clears the latch, whether it is taken or refused. At reset, all protection bits come up set, so the array starts fully guarded.

A small state machine runs each attempt. The states are `ST_IDLE`, `ST_CHECK`, `ST_COMMIT` and `ST_REFUSE`, with these transitions:
- `ST_IDLE` goes to `ST_CHECK` on a request.
- `ST_CHECK` goes to `ST_COMMIT` when the write is granted.
- `ST_CHECK` goes to `ST_REFUSE` when the write is denied.
- `ST_COMMIT` and `ST_REFUSE` each return to `ST_IDLE` unconditionally.

Top module: `srl_status_lock`

## Requirements
- R1: After reset the status byte reads 0xBC. The layout is: bit 7 is the lock-down bit (1), bits 5:2 are block-protect bits 3..0 (all 1), bit 1 is the write-enable latch (0), and bits 6 and 0 read 0.
- R2: A pulse on `wel_set` sets the latch. Status bit 1 and `wel_q` then read 1. `bp_o` always equals status bits 5:2.
- R3: A write is refused while `wp_n` is low and the stored lock-down bit is 1, even when the latch is set. The lock-down and block-protect bits keep their values.
- R4: While `wp_n` is low and the lock-down bit is 0, a write with the latch set is accepted. Data bit 7 loads the lock-down bit and data bits 5:2 load the block-protect bits.
- R5: While `wp_n` is high, a write with the latch set is accepted whatever the lock-down bit holds.
- R6: A write attempted with the latch clear is refused, and the stored bits do not change.
- R7: Any accepted or refused attempt clears the latch. A `wel_set` pulse in the decision cycle loses to that clear. A `wel_set` pulse in the same cycle as the request counts for that request.
- R8: Data bits 6, 1 and 0 are ignored. Bits 6 and 0 of the status byte read 0 after any write.
- R9: The request is taken in `ST_IDLE` at a clock edge. `wp_n` and the latch are judged at the next edge. Exactly one of `wr_accept` or `wr_reject` then pulses for one cycle, alongside the updated status. Requests that arrive while an attempt is in progress are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrsr_req | input | 1 | One-cycle write-status request from the decoder |
| wrsr_data | input | 8 | Byte to be written |
| wp_n | input | 1 | Write-protect pin, active low |
| wel_set | input | 1 | Pulse that sets the write-enable latch |
| stat_q | output | 8 | Current status byte |
| bp_o | output | 4 | Block-protect field for array protection |
| wel_q | output | 1 | Write-enable latch |
| wr_accept | output | 1 | One-cycle pulse: write taken |
| wr_reject | output | 1 | One-cycle pulse: write refused |

## Verification
Two latch operations can land in the same cycle: a set pulse from the command path and the clear caused by an attempt. Both orderings are provoked directly. In the first, `wel_set` is driven together with the request, and the bench expects an accept with the latch ending at 0. In the second, `wel_set` is driven during the decision cycle, and the bench expects the latch to read 0 afterwards. A held request that overlaps a running attempt is also checked, to confirm that no second outcome pulse appears.

// File: rtl/srl_pkg.sv
package srl_pkg;

    localparam int SR_W    = 8;
    localparam int BP_W    = 4;
    localparam int BPL_POS = 7;
    localparam int BP_LSB  = 2;
    localparam int WEL_POS = 1;

    localparam logic [BP_W-1:0] BP_RST  = '1;
    localparam logic            BPL_RST = 1'b1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CHECK  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_REFUSE = 2'd3
    } srl_state_e;

endpackage

// File: rtl/srl_wel_latch.sv
module srl_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end
    end

endmodule

// File: rtl/srl_lock_rule.sv
module srl_lock_rule (
    input  logic wp_n_i,
    input  logic bpl_i,
    input  logic wel_i,
    output logic grant_o
);

    logic locked;

    always_comb begin
        locked  = !wp_n_i && bpl_i;
        grant_o = wel_i && !locked;
    end

endmodule

// File: rtl/srl_fsm.sv
module srl_fsm
    import srl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic grant_i,
    output logic cap_en_o,
    output logic load_en_o,
    output logic wel_clr_o,
    output logic accept_o,
    output logic reject_o
);

    srl_state_e state_q;
    srl_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_i) state_d = ST_CHECK;
            ST_CHECK:  state_d = grant_i ? ST_COMMIT : ST_REFUSE;
            ST_COMMIT: state_d = ST_IDLE;
            ST_REFUSE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cap_en_o  = 1'b0;
        load_en_o = 1'b0;
        wel_clr_o = 1'b0;
        accept_o  = 1'b0;
        reject_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:   cap_en_o = req_i;
            ST_CHECK: begin
                wel_clr_o = 1'b1;
                load_en_o = grant_i;
            end
            ST_COMMIT: accept_o = 1'b1;
            ST_REFUSE: reject_o = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/srl_stat_reg.sv
module srl_stat_reg
    import srl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load_en_i,
    input  logic            wr_bpl_i,
    input  logic [BP_W-1:0] wr_bp_i,
    input  logic            wel_i,
    output logic [SR_W-1:0] stat_o,
    output logic [BP_W-1:0] bp_o
);

    logic bpl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bpl_q <= BPL_RST;
        end else if (load_en_i) begin
            bpl_q <= wr_bpl_i;
        end
    end

    generate
        for (genvar i = 0; i < BP_W; i++) begin : g_bp
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bp_o[i] <= BP_RST[i];
                end else if (load_en_i) begin
                    bp_o[i] <= wr_bp_i[i];
                end
            end
        end
    endgenerate

    always_comb begin
        stat_o                   = '0;
        stat_o[BPL_POS]          = bpl_q;
        stat_o[BP_LSB +: BP_W]   = bp_o;
        stat_o[WEL_POS]          = wel_i;
    end

endmodule

// File: rtl/srl_status_lock.sv
module srl_status_lock
    import srl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wrsr_req,
    input  logic [SR_W-1:0] wrsr_data,
    input  logic            wp_n,
    input  logic            wel_set,
    output logic [SR_W-1:0] stat_q,
    output logic [BP_W-1:0] bp_o,
    output logic            wel_q,
    output logic            wr_accept,
    output logic            wr_reject
);

    logic            cap_en;
    logic            load_en;
    logic            wel_clr;
    logic            grant;
    logic            hold_bpl;
    logic [BP_W-1:0] hold_bp;
    logic            spare_bits_unused;

    // Bits outside the protection fields are read-only; drop them here.
    assign spare_bits_unused = ^{wrsr_data[6], wrsr_data[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_bpl <= 1'b0;
            hold_bp  <= '0;
        end else if (cap_en) begin
            hold_bpl <= wrsr_data[BPL_POS];
            hold_bp  <= wrsr_data[BP_LSB +: BP_W];
        end
    end

    srl_wel_latch u_wel (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wel_set),
        .clr_i (wel_clr),
        .q_o   (wel_q)
    );

    srl_lock_rule u_rule (
        .wp_n_i  (wp_n),
        .bpl_i   (stat_q[BPL_POS]),
        .wel_i   (wel_q),
        .grant_o (grant)
    );

    srl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (wrsr_req),
        .grant_i   (grant),
        .cap_en_o  (cap_en),
        .load_en_o (load_en),
        .wel_clr_o (wel_clr),
        .accept_o  (wr_accept),
        .reject_o  (wr_reject)
    );

    srl_stat_reg u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en_i (load_en),
        .wr_bpl_i  (hold_bpl),
        .wr_bp_i   (hold_bp),
        .wel_i     (wel_q),
        .stat_o    (stat_q),
        .bp_o      (bp_o)
    );

endmodule

// File: rtl/srl_status_lock_chk.sv
module srl_status_lock_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n,
    input logic [7:0] stat_q,
    input logic       wel_q,
    input logic       wr_accept,
    input logic       wr_reject
);

    p_reset_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> stat_q == 8'hBC);

    p_lock_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> ($past(wp_n) || !$past(stat_q[7])));

    p_reject_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> stat_q[7:2] == $past(stat_q[7:2]));

    p_need_wel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |-> $past(wel_q));

    p_wel_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept || wr_reject) |-> !wel_q);

    p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_accept && wr_reject));

    p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept || wr_reject) |=> !(wr_accept || wr_reject));

endmodule

bind srl_status_lock srl_status_lock_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_n      (wp_n),
    .stat_q    (stat_q),
    .wel_q     (wel_q),
    .wr_accept (wr_accept),
    .wr_reject (wr_reject)
);

// File: tb/sim_srl_status_lock.sv
`timescale 1ns/1ps
module sim_srl_status_lock;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wrsr_req = 1'b0;
    logic [7:0] wrsr_data = 8'h00;
    logic       wp_n = 1'b1;
    logic       wel_set = 1'b0;
    logic [7:0] stat_q;
    logic [3:0] bp_o;
    logic       wel_q;
    logic       wr_accept;
    logic       wr_reject;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    srl_status_lock u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wrsr_req  (wrsr_req),
        .wrsr_data (wrsr_data),
        .wp_n      (wp_n),
        .wel_set   (wel_set),
        .stat_q    (stat_q),
        .bp_o      (bp_o),
        .wel_q     (wel_q),
        .wr_accept (wr_accept),
        .wr_reject (wr_reject)
    );

    // {set_wel, wp_n, data[7:0], exp_accept, exp_stat[7:0]}
    localparam int NV = 10;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 1'b0, 8'h00, 1'b0, 8'hBC},  // R3 locked
        {1'b1, 1'b1, 8'h00, 1'b1, 8'h00},  // R5 pin high
        {1'b0, 1'b1, 8'hFF, 1'b0, 8'h00},  // R6 no latch
        {1'b1, 1'b0, 8'h54, 1'b1, 8'h14},  // R4, R8 bit6 ignored
        {1'b1, 1'b0, 8'hBF, 1'b1, 8'hBC},  // R4, R8 bits 1,0 ignored
        {1'b1, 1'b0, 8'h00, 1'b0, 8'hBC},  // R3 relocked
        {1'b1, 1'b1, 8'h83, 1'b1, 8'h80},  // R5 with lock bit set
        {1'b1, 1'b0, 8'h3C, 1'b0, 8'h80},  // R3
        {1'b1, 1'b1, 8'h28, 1'b1, 8'h28},  // R5
        {1'b0, 1'b0, 8'hFF, 1'b0, 8'h28}   // R6
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Request issued at a negedge; outcome sampled two negedges later.
    task automatic attempt(input logic set_wel, input logic pin, input logic [7:0] d,
                           input logic same_cycle_set);
        @(negedge clk);
        wp_n = pin;
        if (set_wel && !same_cycle_set) begin
            wel_set = 1'b1;
            @(negedge clk);
            wel_set = 1'b0;
        end
        wrsr_req  = 1'b1;
        wrsr_data = d;
        wel_set   = set_wel && same_cycle_set;
        @(negedge clk);
        wrsr_req = 1'b0;
        wel_set  = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset status", stat_q, 8'hBC);
        check("R1 reset latch", wel_q, 1'b0);
        check("R2 reset bp_o", bp_o, 4'hF);

        @(negedge clk);
        wel_set = 1'b1;
        @(negedge clk);
        wel_set = 1'b0;
        check("R2 latch set", wel_q, 1'b1);
        check("R2 status bit1", stat_q, 8'hBE);
        @(negedge clk);
        wel_set = 1'b1;
        wrsr_req = 1'b0;
        @(negedge clk);
        wel_set = 1'b0;

        // Clear the latch through a refused attempt before the table.
        attempt(1'b0, 1'b0, 8'h00, 1'b0);
        check("R7 latch cleared", wel_q, 1'b0);
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [18:0] v;
            v = VEC[i];
            attempt(v[18], v[17], v[16:9], 1'b0);
            check($sformatf("R9 accept vec%0d", i), wr_accept, v[8]);
            check($sformatf("R9 reject vec%0d", i), wr_reject, !v[8]);
            check($sformatf("R4 status vec%0d", i), stat_q, v[7:0]);
            check($sformatf("R2 bp_o vec%0d", i), bp_o, v[5:2]);
            check($sformatf("R7 latch vec%0d", i), wel_q, 1'b0);
            @(negedge clk);
            check($sformatf("R9 pulse end vec%0d", i), wr_accept | wr_reject, 1'b0);
        end

        // R7: set pulse together with the request counts; stat 0x28 -> 0xB0 (pin high)
        attempt(1'b1, 1'b1, 8'hB2, 1'b1);
        check("R7 same-cycle set accepts", wr_accept, 1'b1);
        check("R8 status after B2", stat_q, 8'hB0);
        @(negedge clk);

        // R7: set pulse in the decision cycle loses to the clear.
        @(negedge clk);
        wp_n = 1'b0;
        wrsr_req = 1'b1;
        wrsr_data = 8'h00;
        @(negedge clk);
        wrsr_req = 1'b0;
        wel_set = 1'b1;
        @(negedge clk);
        wel_set = 1'b0;
        check("R7 decision-cycle set loses", wel_q, 1'b0);
        check("R6 refused without latch", wr_reject, 1'b1);
        check("R3 status kept", stat_q, 8'hB0);
        @(negedge clk);

        // R9: request held across a running attempt is dropped.
        wp_n = 1'b1;
        wel_set = 1'b1;
        @(negedge clk);
        wel_set = 1'b0;
        wrsr_req = 1'b1;
        wrsr_data = 8'h04;
        @(negedge clk);
        @(negedge clk);
        wrsr_req = 1'b0;
        check("R9 first accept", wr_accept, 1'b1);
        check("R5 status 04", stat_q, 8'h04);
        @(negedge clk);
        check("R9 no second pulse a", wr_accept | wr_reject, 1'b0);
        @(negedge clk);
        check("R9 no second pulse b", wr_accept | wr_reject, 1'b0);

        // R1: reset restores the protected state.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset again", stat_q, 8'hBC);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule